// File: doc/BRIEF.md
# Write-Only Display Bus Slave Receiver

This block is the serial front end of a display driver that can only be written. It watches oversampled I2C clock and data lines and finds START and STOP conditions. It checks the address byte against a fixed pattern, one bit of which is taken from a strap pin. Because of that strap bit, two groups of drivers can share one bus and each group answers only its own address. The slave never sends data. Its only action on SDA is to pull the line low to acknowledge a byte.

Once an address has been accepted, the block reads a control byte. The control byte says where the next bytes go: either to a display-RAM write port or to a command port. It also says whether one data byte follows and then a new control byte, or whether every byte up to the STOP is data. Each data byte is delivered as a one-cycle strobe, together with the byte and a flag that tells RAM data from command data.

Top module: `wdisp_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 0,1,1,1,0,0 followed by the `addr_strap` level, with bit 0 (the direction bit) equal to 0, is acknowledged.
- R2: An address byte with bit 0 equal to 1 (a read) is not acknowledged. No byte after it is acknowledged or strobed until the next START.
- R3: If bit 1 of the address byte differs from `addr_strap`, the transfer is ignored until the next START: no acknowledge and no strobe.
- R4: In an accepted transfer, every byte is acknowledged. `sda_oe` is high for the whole SCL-high period of the ninth clock. It goes low after the SCL fall that ends that clock, and it is low during the high period of every data bit.
- R5: In a control byte, bit 6 selects the destination of the data bytes that follow it: 1 routes them to RAM (`wr_is_ram`=1), 0 routes them to the command port (`wr_is_ram`=0).
- R6: If bit 7 of the control byte is 1, exactly one data byte follows and then a new control byte. If bit 7 is 0, every byte up to the STOP is data, and the number of such bytes is unlimited.
- R7: Each data byte produces exactly one single-cycle `wr_strobe`, with `wr_data` holding the byte received MSB first.
- R8: After a STOP, the slave is idle. Clock pulses without a new START cause no acknowledge and no strobe.
- R9: A repeated START in the middle of a transfer restarts address matching, and `sda_oe` is low right after it.
- R10: After reset, `sda_oe` and `wr_strobe` are low.
- R11: Bits 5 to 0 of a control byte have no effect on routing or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as sensed (asynchronous) |
| sda_in | input | 1 | Bus data line as sensed (asynchronous) |
| addr_strap | input | 1 | Strap level that must equal address bit 1 |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| wr_strobe | output | 1 | One-cycle pulse marking a received data byte |
| wr_data | output | 8 | Data byte, valid while `wr_strobe` is high |
| wr_is_ram | output | 1 | 1: byte is for display RAM, 0: byte is for the command port |

## Verification
The bench aims at the framing corners:
- A control byte with bit 7 set, followed by another control byte that switches the destination. A design that mis-sequenced this would send the following byte to the wrong port or would treat data as a control byte.
- Read requests and strap mismatches. A design that got these wrong would acknowledge, or would strobe the bytes that follow.
- A repeated START after a rejected address, and stray clocks after a STOP. Here a wrong design would keep an old state alive.

The bench also checks `sda_oe` on every clock while SCL is high. This catches an acknowledge that is released too early, or one that spills into the next data bit.

// File: rtl/wdisp_pkg.sv
package wdisp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_SKIP
  } frame_st_t;

  // Address accepted: fixed upper six bits, strap bit, write direction (R1, R2, R3)
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic strap,
                                    input logic [5:0] fixed_hi);
    return (b[7:2] == fixed_hi) && (b[1] == strap) && !b[0];
  endfunction

  // Control byte bit 7: one data byte then another control byte (R6)
  function automatic logic ctrl_more(input logic [BYTE_W-1:0] b);
    return b[7];
  endfunction

  // Control byte bit 6: RAM destination when set (R5)
  function automatic logic ctrl_ram(input logic [BYTE_W-1:0] b);
    return b[6];
  endfunction

endpackage

// File: rtl/wdisp_sync.sv
module wdisp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  // Resets to ones: an idle bus reads high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/wdisp_busev.sv
module wdisp_busev (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  wire scl_held_high = scl_s && scl_q;

  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign start_evt = scl_held_high && sda_q && !sda_s;
  assign stop_evt  = scl_held_high && !sda_q && sda_s;

endmodule

// File: rtl/wdisp_frame.sv
module wdisp_frame
  import wdisp_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_bit,
  input  logic              strap,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_is_ram,
  output logic              byte_done,
  output frame_st_t         st
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic              nine;      // inside the acknowledge clock
  logic              ack_due;
  logic              more_q;
  logic              ram_q;

  wire [BYTE_W-1:0] rx_byte = {shreg, sda_bit};
  wire              bit_take = scl_rise && !nine && (bit_cnt < FULL_CNT);

  assign byte_done = (st != ST_IDLE) && bit_take && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      nine      <= 1'b0;
      ack_due   <= 1'b0;
      more_q    <= 1'b0;
      ram_q     <= 1'b0;
      sda_oe    <= 1'b0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
      wr_is_ram <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      if (start_evt || stop_evt) begin
        // R9: a START (also a repeated one) re-arms matching; R8: STOP idles
        st      <= start_evt ? ST_ADDR : ST_IDLE;
        bit_cnt <= '0;
        nine    <= 1'b0;
        ack_due <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (bit_take) begin
          shreg   <= rx_byte[BYTE_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            ack_due <= 1'b0;
            unique case (st)
              ST_ADDR: begin
                if (addr_hit(rx_byte, strap, ADDR_HI)) begin
                  ack_due <= 1'b1;
                  st      <= ST_CTRL;
                end else begin
                  st      <= ST_SKIP;
                end
              end
              ST_CTRL: begin
                ack_due <= 1'b1;
                more_q  <= ctrl_more(rx_byte);
                ram_q   <= ctrl_ram(rx_byte);
                st      <= ST_DATA;
              end
              ST_DATA: begin
                ack_due   <= 1'b1;
                wr_strobe <= 1'b1;
                wr_data   <= rx_byte;
                wr_is_ram <= ram_q;
                if (more_q) st <= ST_CTRL;
              end
              default: ;
            endcase
          end
        end else if (scl_fall) begin
          if (nine) begin
            // R4: release on the fall that ends the acknowledge clock
            nine    <= 1'b0;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
          end else if (bit_cnt == FULL_CNT) begin
            nine   <= 1'b1;
            sda_oe <= ack_due;
          end
        end
      end
    end
  end

endmodule

// File: rtl/wdisp_i2c_slave.sv
module wdisp_i2c_slave
  import wdisp_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b011100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_strap,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_is_ram
);

  logic [1:0] line_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;
  logic       byte_done;
  frame_st_t  frame_st;

  wdisp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  wdisp_busev u_busev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  wdisp_frame #(.ADDR_HI(ADDR_HI)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_bit  (sda_s),
    .strap    (addr_strap),
    .sda_oe   (sda_oe),
    .wr_strobe(wr_strobe),
    .wr_data  (wr_data),
    .wr_is_ram(wr_is_ram),
    .byte_done(byte_done),
    .st       (frame_st)
  );

endmodule

// File: rtl/wdisp_chk.sv
module wdisp_chk
  import wdisp_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_s,
  input logic      sda_oe,
  input logic      wr_strobe,
  input logic      byte_done,
  input logic      start_evt,
  input frame_st_t st
);

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R4

  AST_OE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R4

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe); // R7

  AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(byte_done)); // R7

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && st == ST_ADDR)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!sda_oe && !wr_strobe)); // R8

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> (!sda_oe && !wr_strobe)); // R3

endmodule

bind wdisp_i2c_slave wdisp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .wr_strobe(wr_strobe),
  .byte_done(byte_done),
  .start_evt(start_evt),
  .st       (frame_st)
);

// File: tb/wdisp_i2c_slave_tb.sv
`timescale 1ns/1ps
module wdisp_i2c_slave_tb;

  localparam int Q  = 8;        // clocks per quarter bit
  localparam int WD = 150000;   // watchdog in clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       strap = 1'b0;
  logic       sda_oe;
  logic       wr_strobe;
  logic [7:0] wr_data;
  logic       wr_is_ram;

  always #2.5 clk = ~clk;

  wire sda_bus = m_sda & ~sda_oe;

  wdisp_i2c_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (m_scl),
    .sda_in    (sda_bus),
    .addr_strap(strap),
    .sda_oe    (sda_oe),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .wr_is_ram (wr_is_ram)
  );

  int         total = 0;
  int         bad   = 0;
  string      cur_req = "R10";
  int         chk_mode = 0;     // 0 none, 1 expect released, 2 expect exp_ack
  logic       exp_ack = 1'b0;
  logic       exp_oe;
  logic [8:0] exp_q[$];
  logic [8:0] e_val;

  // Behavioural reference: 0 idle, 1 address, 2 control, 3 data, 4 ignore
  int   ms = 0;
  logic m_more = 1'b0;
  logic m_ram  = 1'b0;

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_mode != 0) begin
        exp_oe = (chk_mode == 2) ? exp_ack : 1'b0;
        total++;
        if (sda_oe !== exp_oe) begin
          bad++;
          $display("FAIL %s sda_oe act=%0b exp=%0b t=%0t", cur_req, sda_oe, exp_oe, $time);
        end
      end
      if (wr_strobe) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL %s unexpected strobe act=%0b/%02h exp=none", cur_req, wr_is_ram, wr_data);
        end else begin
          e_val = exp_q.pop_front();
          if ({wr_is_ram, wr_data} !== e_val) begin
            bad++;
            $display("FAIL %s strobe act=%0b/%02h exp=%0b/%02h", cur_req,
                     wr_is_ram, wr_data, e_val[8], e_val[7:0]);
          end
        end
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait();
    m_scl = 1'b0; qwait();
    ms = 1;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait(); qwait();
    ms = 0;
  endtask

  task automatic clk_bit(input logic v, input int mode);
    m_sda = v; qwait();
    m_scl = 1'b1; chk_mode = mode; qwait(); qwait();
    chk_mode = 0; m_scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic ack;
    ack = 1'b0;
    case (ms)
      1: if (b[7:1] == {6'b011100, strap} && !b[0]) begin ack = 1'b1; ms = 2; end
         else ms = 4;
      2: begin ack = 1'b1; m_more = b[7]; m_ram = b[6]; ms = 3; end
      3: begin ack = 1'b1; exp_q.push_back({m_ram, b}); if (m_more) ms = 2; end
      default: ack = 1'b0;
    endcase
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1);
    exp_ack = ack;
    clk_bit(1'b1, 2);
  endtask

  task automatic drain_check();
    repeat (20) @(posedge clk);
    @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s missing strobes act=0 exp=%0d", cur_req, exp_q.size());
    end
    exp_q.delete();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    total++;
    if (sda_oe !== 1'b0 || wr_strobe !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset act=%0b%0b exp=00", sda_oe, wr_strobe);
    end

    // R1 R5 R7: RAM run until STOP, MSB-first bytes
    cur_req = "R7";
    bus_start(); send_byte(8'h70); send_byte(8'h40);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00); send_byte(8'h81);
    bus_stop(); drain_check();

    // R5 R6: command run, many bytes until STOP
    cur_req = "R6";
    bus_start(); send_byte(8'h70); send_byte(8'h00);
    for (int k = 0; k < 10; k++) send_byte(8'(k * 23 + 1));
    bus_stop(); drain_check();

    // R6 R11: chained control bytes with noise in bits 5..0
    cur_req = "R11";
    bus_start(); send_byte(8'h70);
    send_byte(8'hC0); send_byte(8'h11);
    send_byte(8'h9F); send_byte(8'h22);
    send_byte(8'hEA); send_byte(8'h99);
    send_byte(8'h3F); send_byte(8'h33); send_byte(8'h44);
    bus_stop(); drain_check();

    cur_req = "R5";
    bus_start(); send_byte(8'h70); send_byte(8'h7F); send_byte(8'h5A); send_byte(8'hC3);
    bus_stop(); drain_check();

    // R2: read request refused, rest ignored
    cur_req = "R2";
    bus_start(); send_byte(8'h71); send_byte(8'h40); send_byte(8'h12); send_byte(8'h34);
    bus_stop(); drain_check();

    // R3: strap mismatch ignored
    cur_req = "R3";
    bus_start(); send_byte(8'h72); send_byte(8'h40); send_byte(8'h56);
    bus_stop(); drain_check();

    // R1: strap high selects the other address
    cur_req = "R1";
    strap = 1'b1;
    bus_start(); send_byte(8'h70); send_byte(8'h40); send_byte(8'h77);
    bus_stop(); drain_check();
    bus_start(); send_byte(8'h72); send_byte(8'h40); send_byte(8'h78); send_byte(8'h79);
    bus_stop(); drain_check();
    strap = 1'b0;

    // R9: repeated START after accepted and after rejected address
    cur_req = "R9";
    bus_start(); send_byte(8'h70); send_byte(8'h40); send_byte(8'h55);
    bus_start(); send_byte(8'h72); send_byte(8'h00); send_byte(8'h66);
    bus_start(); send_byte(8'h70); send_byte(8'h00); send_byte(8'h67);
    bus_stop(); drain_check();

    // R8: clocks after STOP with no START
    cur_req = "R8";
    m_scl = 1'b0; qwait();
    send_byte(8'h70); send_byte(8'h40); send_byte(8'h99);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); qwait();
    drain_check();

    // R4: acknowledge still correct after the idle clocks
    cur_req = "R4";
    bus_start(); send_byte(8'h70); send_byte(8'hC0); send_byte(8'hF0);
    send_byte(8'h00); send_byte(8'h0F);
    bus_stop(); drain_check();

    summary();
    $finish;
  end

endmodule